// File: doc/BRIEF.md
# Idle Compute Unit Watchdog

This block watches every wavefront slot of a compute unit and keeps one shared count of how many of them sit in an idle status. Each slot reports its status changes on a per-slot lane made of a valid bit, the status it is leaving and the status it is entering. The block folds all lanes reported in one cycle into a single net change of the shared count.

When the count reaches the number of slots, the whole unit is idle. The block then records the value of its free-running cycle counter. Later a slot may leave idle while the unit is still fully idle. At that point the block measures how long the unit sat idle. If that span is at least the programmed timeout, it raises a fault that stays set until reset. A timeout of zero switches all tracking off.

The count must stay between zero and the slot total. Any update that would push it outside that range sets a sticky error flag and clamps the count.

Top module: `cu_idle_watchdog`

## Requirements
- R1: Status codes are 3 bits wide. Slot k uses bits [3k+2:3k] of both status buses. Codes 0 (stopped), 2 (stalled), 3 (waiting on counters) and 4 (barrier) are idle. Codes 1 (running), 5 (returning), 6 and 7 are active.
- R2: A valid lane whose new status differs from its old status and is idle adds one to the count. This rule wins over R3, so an idle-to-different-idle change also adds one.
- R3: A valid lane whose old status is idle and whose new status differs and is active takes one from the count. A lane whose new status equals its old status, a lane whose valid is low, and an active-to-active change leave the count unchanged.
- R4: All lanes valid in one cycle are combined into one net change. `idle_count` shows the result from the clock edge that samples the updates.
- R5: `all_idle` is high exactly when `idle_count` equals the slot total, WAVES_PER_SIMD times NUM_SIMD (8 by default).
- R6: The counter value is captured on the edge where the count becomes equal to the total. A decrement applied while the count equals the total is a wake. A wake raises `timeout_fault` on the same edge when the number of clock edges since the capture is at least `timeout_cycles`. A slot that leaves idle while the count is below the total never raises the fault.
- R7: `timeout_fault` stays high until reset.
- R8: While `timeout_cycles` is zero, the count does not change, no fault is raised and no error is raised.
- R9: An update that would take the count below zero or above the total sets the sticky `count_error` and clamps the count to 0 or to the total.
- R10: A synchronous active-low reset clears the count, the fault and the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timeout_cycles | input | TIME_W | Idle timeout in cycles; zero disables tracking |
| slot_valid | input | NUM_SLOTS | One bit per slot, high when that slot reports a change |
| slot_old_status | input | NUM_SLOTS*3 | Status each slot is leaving |
| slot_new_status | input | NUM_SLOTS*3 | Status each slot is entering |
| idle_count | output | CNT_W | Number of idle slots |
| all_idle | output | 1 | Every slot is idle |
| timeout_fault | output | 1 | Sticky hang indication |
| count_error | output | 1 | Sticky count range violation |

## Verification
The checker watches several rules on every cycle:
- the count stays within the slot total;
- the fault and the error flags are sticky;
- the count is frozen when no lane is valid or the timeout is zero;
- a fault can only rise out of a fully idle unit.

Only the bench scenarios can show the rest:
- that each status class gives the right increment or decrement;
- that simultaneous lanes net out correctly;
- that the elapsed-time comparison switches exactly at the timeout boundary (one cycle short and exactly on it);
- that an underflow or overflow clamps the count.

// File: rtl/cuw_pkg.sv
// Shared status encoding and the idle classification for the watchdog.
// Assumes a 3-bit status code per wavefront slot.
package cuw_pkg;
    localparam int STATUS_W = 3;

    typedef enum logic [STATUS_W-1:0] {
        ST_STOPPED   = 3'd0,
        ST_RUNNING   = 3'd1,
        ST_STALLED   = 3'd2,
        ST_WAITCNT   = 3'd3,
        ST_BARRIER   = 3'd4,
        ST_RETURNING = 3'd5,
        ST_RSVD6     = 3'd6,
        ST_RSVD7     = 3'd7
    } wave_status_e;

    // True for the four statuses that count as idle.
    function automatic logic is_idle(input logic [STATUS_W-1:0] s);
        return (s == ST_STOPPED) || (s == ST_STALLED) ||
               (s == ST_WAITCNT) || (s == ST_BARRIER);
    endfunction
endpackage

// File: rtl/cuw_slot_eval.sv
// Classifies one slot's status change as an idle increment or decrement.
// Assumes old/new are only meaningful while valid is high.
module cuw_slot_eval
    import cuw_pkg::*;
(
    input  logic                valid,
    input  logic [STATUS_W-1:0] old_status,
    input  logic [STATUS_W-1:0] new_status,
    output logic                inc,
    output logic                dec
);
    logic changed;

    // Entering idle wins; leaving idle only counts when the target is active.
    always_comb begin
        changed = valid && (old_status != new_status);
        inc     = changed && is_idle(new_status);
        dec     = changed && !is_idle(new_status) && is_idle(old_status);
    end
endmodule

// File: rtl/cuw_net_sum.sv
// Folds per-slot increment and decrement flags into one signed net change.
// Assumes CNT_W bits can hold NUM_SLOTS.
module cuw_net_sum #(
    parameter int NUM_SLOTS = 8,
    parameter int CNT_W     = 4
) (
    input  logic [NUM_SLOTS-1:0]    inc_vec,
    input  logic [NUM_SLOTS-1:0]    dec_vec,
    output logic signed [CNT_W+1:0] net
);
    logic [CNT_W:0] n_inc;
    logic [CNT_W:0] n_dec;

    // Population count of both flag vectors, then their difference.
    always_comb begin
        n_inc = '0;
        n_dec = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            n_inc = n_inc + {{CNT_W{1'b0}}, inc_vec[i]};
            n_dec = n_dec + {{CNT_W{1'b0}}, dec_vec[i]};
        end
        net = $signed({1'b0, n_inc}) - $signed({1'b0, n_dec});
    end
endmodule

// File: rtl/cuw_time_keeper.sv
// Free-running cycle counter with a capture register for the moment the
// unit became fully idle, and a comparison of the elapsed span with a limit.
// Assumes wrap-around subtraction is acceptable for the span.
module cuw_time_keeper #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [TIME_W-1:0] limit,
    output logic              expired
);
    logic [TIME_W-1:0] now_q;
    logic [TIME_W-1:0] stamp_q;

    // Advance the time base every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + 1'b1;
    end

    // Record the time of entry into full idle.
    always_ff @(posedge clk) begin
        if (!rst_n)       stamp_q <= '0;
        else if (capture) stamp_q <= now_q;
    end

    // Span since capture compared against the programmed limit.
    always_comb expired = (now_q - stamp_q) >= limit;
endmodule

// File: rtl/cu_idle_watchdog.sv
// Shared idle counter for all wavefront slots of a compute unit with a
// wake-time hang check. Assumes each slot reports a change at most once
// per cycle and that old_status matches the slot's previous report.
module cu_idle_watchdog
    import cuw_pkg::*;
#(
    parameter int WAVES_PER_SIMD = 4,
    parameter int NUM_SIMD       = 2,
    parameter int TIME_W         = 32,
    parameter int NUM_SLOTS      = WAVES_PER_SIMD * NUM_SIMD,
    parameter int CNT_W          = $clog2(NUM_SLOTS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [TIME_W-1:0]             timeout_cycles,
    input  logic [NUM_SLOTS-1:0]          slot_valid,
    input  logic [NUM_SLOTS*STATUS_W-1:0] slot_old_status,
    input  logic [NUM_SLOTS*STATUS_W-1:0] slot_new_status,
    output logic [CNT_W-1:0]              idle_count,
    output logic                          all_idle,
    output logic                          timeout_fault,
    output logic                          count_error
);
    localparam logic [CNT_W-1:0]        TOTAL_C = CNT_W'(NUM_SLOTS);
    localparam logic signed [CNT_W+1:0] TOTAL_S = (CNT_W+2)'(NUM_SLOTS);

    logic [NUM_SLOTS-1:0]    inc_vec;
    logic [NUM_SLOTS-1:0]    dec_vec;
    logic signed [CNT_W+1:0] net;
    logic signed [CNT_W+1:0] sum;
    logic [CNT_W-1:0]        count_q;
    logic [CNT_W-1:0]        count_nx;
    logic                    range_bad;
    logic                    track_en;
    logic                    wake;
    logic                    capture;
    logic                    expired;
    logic                    fault_q;
    logic                    err_q;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        cuw_slot_eval u_eval (
            .valid      (slot_valid[k]),
            .old_status (slot_old_status[k*STATUS_W +: STATUS_W]),
            .new_status (slot_new_status[k*STATUS_W +: STATUS_W]),
            .inc        (inc_vec[k]),
            .dec        (dec_vec[k])
        );
    end

    cuw_net_sum #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_sum (
        .inc_vec (inc_vec),
        .dec_vec (dec_vec),
        .net     (net)
    );

    // Apply the net change and clamp it into the legal range.
    always_comb begin
        sum       = $signed({2'b00, count_q}) + net;
        range_bad = 1'b0;
        count_nx  = sum[CNT_W-1:0];
        if (sum < 0) begin
            range_bad = 1'b1;
            count_nx  = '0;
        end else if (sum > TOTAL_S) begin
            range_bad = 1'b1;
            count_nx  = TOTAL_C;
        end
    end

    // Decide when tracking runs, when to stamp and when a wake is seen.
    always_comb begin
        track_en = (timeout_cycles != '0);
        wake     = track_en && (count_q == TOTAL_C) && (|dec_vec);
        capture  = track_en && (count_nx == TOTAL_C) && (count_q != TOTAL_C);
    end

    cuw_time_keeper #(.TIME_W(TIME_W)) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .limit   (timeout_cycles),
        .expired (expired)
    );

    // Idle count register, frozen while tracking is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (track_en) count_q <= count_nx;
    end

    // Sticky hang and range-error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (wake && expired)       fault_q <= 1'b1;
            if (track_en && range_bad) err_q   <= 1'b1;
        end
    end

    assign idle_count    = count_q;
    assign all_idle      = (count_q == TOTAL_C);
    assign timeout_fault = fault_q;
    assign count_error   = err_q;
endmodule

// File: rtl/cuw_checker.sv
// Cycle-by-cycle properties of the idle watchdog, attached by bind.
// Assumes the same parameters as the watched instance.
module cuw_checker #(
    parameter int NUM_SLOTS = 8,
    parameter int CNT_W     = 4,
    parameter int TIME_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [TIME_W-1:0]    timeout_cycles,
    input logic [NUM_SLOTS-1:0] slot_valid,
    input logic [CNT_W-1:0]     idle_count,
    input logic                 timeout_fault,
    input logic                 count_error
);
    localparam logic [CNT_W-1:0] TOTAL_C = CNT_W'(NUM_SLOTS);

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_count <= TOTAL_C);

    assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid == '0) |=> $stable(idle_count));

    assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_cycles == '0) |=> $stable(idle_count));

    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_fault |=> timeout_fault);

    assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count_error |=> count_error);

    assert_fault_from_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_fault) |-> ($past(idle_count) == TOTAL_C));
endmodule

bind cu_idle_watchdog cuw_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .CNT_W     (CNT_W),
    .TIME_W    (TIME_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .timeout_cycles (timeout_cycles),
    .slot_valid     (slot_valid),
    .idle_count     (idle_count),
    .timeout_fault  (timeout_fault),
    .count_error    (count_error)
);

// File: tb/cu_idle_watchdog_tb_top.sv
// Self-checking bench: a vector table for the counting rules, then directed
// scenarios for timing, stickiness, disable and range violations.
module cu_idle_watchdog_tb_top;
    localparam int NS = 8;
    localparam int SW = 3;
    localparam int CW = 4;
    localparam int TW = 32;
    localparam int STOP = 0, RUN = 1, STALL = 2, WAITC = 3, BAR = 4, RET = 5;

    function automatic logic [NS*SW-1:0] fld(input int slot, input int st);
        return (NS*SW)'(st) << (slot*SW);
    endfunction

    localparam int NV = 9;
    localparam logic [NS-1:0] T_V [NV] = '{8'h01, 8'h06, 8'h01, 8'h03, 8'hF0,
                                           8'h01, 8'h11, 8'h01, 8'h00};
    localparam logic [NS*SW-1:0] T_O [NV] = '{
        fld(0, RUN), fld(1, RUN) | fld(2, RUN), fld(0, STOP),
        fld(0, STOP) | fld(1, STALL),
        fld(4, RUN) | fld(5, RUN) | fld(6, RUN) | fld(7, RUN),
        fld(0, RUN), fld(0, RUN) | fld(4, BAR), fld(0, STOP), fld(3, RUN)};
    localparam logic [NS*SW-1:0] T_N [NV] = '{
        fld(0, STOP), fld(1, STALL) | fld(2, WAITC), fld(0, STOP),
        fld(0, RUN) | fld(1, RET),
        fld(4, BAR) | fld(5, BAR) | fld(6, BAR) | fld(7, BAR),
        fld(0, RET), fld(0, STOP) | fld(4, RUN), fld(0, STALL), fld(3, STOP)};
    localparam int T_E [NV] = '{1, 3, 3, 1, 5, 5, 5, 6, 6};

    localparam logic [NS*SW-1:0] ALL_RUN = 24'h249249;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TW-1:0]     timeout_cycles = 32'd1000;
    logic [NS-1:0]     slot_valid = '0;
    logic [NS*SW-1:0]  slot_old_status = '0;
    logic [NS*SW-1:0]  slot_new_status = '0;
    logic [CW-1:0]     idle_count;
    logic              all_idle;
    logic              timeout_fault;
    logic              count_error;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cu_idle_watchdog dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .timeout_cycles  (timeout_cycles),
        .slot_valid      (slot_valid),
        .slot_old_status (slot_old_status),
        .slot_new_status (slot_new_status),
        .idle_count      (idle_count),
        .all_idle        (all_idle),
        .timeout_fault   (timeout_fault),
        .count_error     (count_error)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock with the given update; returns at the following negedge.
    task automatic cyc(input logic [NS-1:0] v, input logic [NS*SW-1:0] o,
                       input logic [NS*SW-1:0] n);
        slot_valid      = v;
        slot_old_status = o;
        slot_new_status = n;
        @(posedge clk);
        @(negedge clk);
        slot_valid = '0;
    endtask

    task automatic idle_cycles(input int k);
        for (int i = 0; i < k; i++) cyc('0, '0, '0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        slot_valid = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic chk_reset_state(input string tag);
        chk({tag, " R10 count"}, int'(idle_count), 0);
        chk({tag, " R10 all_idle"}, int'(all_idle), 0);
        chk({tag, " R10 fault"}, int'(timeout_fault), 0);
        chk({tag, " R10 error"}, int'(count_error), 0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        chk_reset_state("initial");

        // Table walk: R1 R2 R3 R4 counting rules
        for (int t = 0; t < NV; t++) begin
            cyc(T_V[t], T_O[t], T_N[t]);
            chk($sformatf("R4 table entry %0d count", t), int'(idle_count), T_E[t]);
            chk($sformatf("R5 table entry %0d all_idle", t), int'(all_idle), 0);
        end

        // Full idle, wake one short of the timeout: no fault (R6)
        do_reset();
        timeout_cycles = 32'd20;
        cyc(8'hFF, ALL_RUN, '0);
        chk("R5 all idle count", int'(idle_count), 8);
        chk("R5 all_idle high", int'(all_idle), 1);
        idle_cycles(18);
        cyc(8'h01, fld(0, STOP), fld(0, RUN));
        chk("R6 wake at 19 no fault", int'(timeout_fault), 0);
        chk("R6 wake count", int'(idle_count), 7);
        chk("R5 all_idle low", int'(all_idle), 0);

        // Idle again, wake exactly at the timeout: fault (R6)
        cyc(8'h01, fld(0, RUN), fld(0, STOP));
        idle_cycles(19);
        cyc(8'h01, fld(0, STOP), fld(0, RUN));
        chk("R6 wake at 20 fault", int'(timeout_fault), 1);
        idle_cycles(3);
        chk("R7 fault sticky", int'(timeout_fault), 1);

        // Reset clears everything (R10)
        do_reset();
        chk_reset_state("after fault");

        // Long idle below total, then a slot leaves: no fault (R6)
        cyc(8'h7F, 24'h049249, '0);
        chk("R6 partial count", int'(idle_count), 7);
        idle_cycles(40);
        cyc(8'h01, fld(0, STOP), fld(0, RUN));
        chk("R6 partial wake no fault", int'(timeout_fault), 0);
        chk("R6 partial wake count", int'(idle_count), 6);

        // Underflow clamps and flags (R9)
        do_reset();
        cyc(8'h01, fld(0, STOP), fld(0, RUN));
        chk("R9 underflow count", int'(idle_count), 0);
        chk("R9 underflow error", int'(count_error), 1);

        // Overflow clamps and flags (R9), idle-to-idle adds one (R2)
        do_reset();
        cyc(8'hFF, ALL_RUN, '0);
        cyc(8'h01, fld(0, STOP), fld(0, STALL));
        chk("R9 overflow count", int'(idle_count), 8);
        chk("R9 overflow error", int'(count_error), 1);

        // Timeout zero disables tracking (R8)
        do_reset();
        timeout_cycles = '0;
        cyc(8'hFF, ALL_RUN, '0);
        chk("R8 disabled count", int'(idle_count), 0);
        chk("R8 disabled all_idle", int'(all_idle), 0);
        cyc(8'h01, fld(0, STOP), fld(0, RUN));
        chk("R8 disabled no error", int'(count_error), 0);
        chk("R8 disabled no fault", int'(timeout_fault), 0);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule